// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block turns two encoder inputs, A and B, into a 32-bit position count. A two-bit source-mode field picks how the inputs become count events. Quadrature mode counts every edge of both inputs for four steps per encoder cycle, with the phase order giving the direction. Pulse-direction mode counts rising edges of A, and the level of B sets the direction. Count-up and count-down modes count edges of A only. In those two modes a clock-rate bit picks between rising edges only and both edges.

The count runs from 0 up to a programmable maximum and wraps at either end. An enable bit gates all counting. Both inputs are synchronised inside the block and edge-detected there. A small register port reads and writes the count, the maximum, the decoder control and the enable. In quadrature mode, a sample in which both inputs change at once is an illegal transition. It produces no count and sets a sticky phase-error flag.

Top module: `qpos_counter`

## Requirements
- R1: After reset the count is 0, the maximum is 32'hFFFF_FFFF, the mode is 0, the clock-rate bit is 0, counting is disabled and the phase-error flag is clear.
- R2: Register port, with reads combinational on `addr`. Address 0 is the count and address 1 is the maximum. Address 2 is the decoder control, with the mode in bits 15:14 and the clock-rate bit in bit 11; all its other bits read 0. At address 3, bit 0 is the enable and bit 1 is the phase-error flag; writing 1 to bit 1 clears the flag.
- R3: While the enable is 0, no input activity changes the count.
- R4: Mode 0 (quadrature): every edge on exactly one input changes the count by one. The sequence AB = 00→10→11→01→00 (A leading) counts up, and the reverse sequence counts down.
- R5: Mode 0: a sample in which A and B both change leaves the count unchanged and sets the phase-error flag. The flag holds until it is cleared through address 3.
- R6: Mode 1 (pulse-direction): each rising edge of A counts up when B is high and down when B is low. Falling edges of A and any edge of B do not count.
- R7: Mode 2 counts up and mode 3 counts down. Both count rising edges of A when the clock-rate bit is 0, and both edges of A when it is 1. B never causes a count.
- R8: Counting up from a value at or above the maximum gives 0. Counting down from 0 gives the maximum.
- R9: The count output changes on the third rising clock edge after an input change: two synchroniser flops, then the counter register.
- R10: A write to the count register in the same cycle as a count event loads the written value, and the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder input A, asynchronous |
| enc_b | input | 1 | Encoder input B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, combinational on addr |
| pos_count | output | 32 | Current position count |
| phase_err | output | 1 | Sticky illegal-transition flag |

## Verification
An input change reaches the count output on the third rising edge after it is driven. The bench drives the inputs on a falling edge and holds them for three falling edges, then compares `pos_count` with its model. The latency check samples after the second and the third falling edge, so it sees the value just before the update and just after it. Register writes take effect on the next rising edge. Read-backs sample the combinational `rd_data` on the following falling edge. The write-priority case places a count write on the exact rising edge at which a pending event would update the counter.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

    localparam int CNT_W  = 32;
    localparam int CTL_W  = 16;
    localparam int MODE_HI = 15;
    localparam int MODE_LO = 14;
    localparam int RATE_BIT = 11;

    typedef enum logic [1:0] {
        SRC_QUAD = 2'd0,
        SRC_DIR  = 2'd1,
        SRC_UP   = 2'd2,
        SRC_DOWN = 2'd3
    } src_mode_e;

    typedef enum logic [1:0] {
        RA_COUNT = 2'd0,
        RA_LIMIT = 2'd1,
        RA_DECODE = 2'd2,
        RA_ENABLE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic bad;
    } step_t;

    typedef struct packed {
        logic a;
        logic b;
    } ab_t;

    // Direction of a legal single-input quadrature move: up when A leads.
    function automatic logic quad_is_up(input ab_t prev, input ab_t cur);
        return cur.a ^ prev.b;
    endfunction

    function automatic logic [CTL_W-1:0] pack_decode(input src_mode_e m, input logic rate);
        logic [CTL_W-1:0] v;
        v = '0;
        v[MODE_HI:MODE_LO] = m;
        v[RATE_BIT] = rate;
        return v;
    endfunction

endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
    parameter int CH = 2,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] raw,
    output logic [CH-1:0] cur,
    output logic [CH-1:0] prev
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], raw[c]};
                last  <= chain[STAGES-1];
            end
        end
        assign cur[c]  = chain[STAGES-1];
        assign prev[c] = last;
    end
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
    import qpos_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_mode_e mode,
    input  logic      rate_both,
    input  ab_t       prev,
    input  ab_t       cur,
    output step_t     step
);
    logic a_edge, b_edge, a_rise;

    assign a_edge = cur.a ^ prev.a;
    assign b_edge = cur.b ^ prev.b;
    assign a_rise = cur.a & ~prev.a;

    always_comb begin
        step = '0;
        unique case (mode)
            SRC_QUAD: begin
                if (a_edge && b_edge) begin
                    step.bad = 1'b1;
                end else if (a_edge || b_edge) begin
                    step.up = quad_is_up(prev, cur);
                    step.dn = ~quad_is_up(prev, cur);
                end
            end
            SRC_DIR: begin
                if (a_rise) begin
                    step.up = cur.b;
                    step.dn = ~cur.b;
                end
            end
            SRC_UP:   step.up = rate_both ? a_edge : a_rise;
            SRC_DOWN: step.dn = rate_both ? a_edge : a_rise;
            default:  step = '0;
        endcase
    end

    p_one_dir_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({step.up, step.dn}) <= 1);

    p_b_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        ((mode == SRC_UP || mode == SRC_DOWN) && !a_edge) |-> !(step.up || step.dn));

    p_dir_needs_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == SRC_DIR && !a_rise) |-> !(step.up || step.dn));
endmodule

// File: rtl/qpos_count.sv
module qpos_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         up,
    input  logic         dn,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = count;
        if (load)
            nxt = load_val;
        else if (en && up)
            nxt = (count >= limit) ? '0 : count + 1'b1;
        else if (en && dn)
            nxt = (count == '0) ? limit : count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end

    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(count));

    p_wrap_up_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && en && up && count >= limit) |=> count == '0);

    p_wrap_dn_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && en && dn && !up && count == '0) |=> count == $past(limit));

    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
    import qpos_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enc_a,
    input  logic         enc_b,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] pos_count,
    output logic         phase_err
);
    logic [1:0]   s_cur, s_prev;
    ab_t          ab_cur, ab_prev;
    step_t        step;
    src_mode_e    mode_q;
    logic         rate_q;
    logic         en_q;
    logic         perr_q;
    logic [W-1:0] limit_q;
    logic         load_cnt;
    logic         clr_perr;

    qpos_sync #(.CH(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({enc_a, enc_b}),
        .cur  (s_cur),
        .prev (s_prev)
    );

    assign ab_cur  = ab_t'(s_cur);
    assign ab_prev = ab_t'(s_prev);

    qpos_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .rate_both (rate_q),
        .prev      (ab_prev),
        .cur       (ab_cur),
        .step      (step)
    );

    assign load_cnt = wr_en && (addr == RA_COUNT);
    assign clr_perr = wr_en && (addr == RA_ENABLE) && wr_data[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= SRC_QUAD;
            rate_q  <= 1'b0;
            en_q    <= 1'b0;
            limit_q <= '1;
        end else if (wr_en) begin
            unique case (addr)
                RA_LIMIT:  limit_q <= wr_data;
                RA_DECODE: begin
                    mode_q <= src_mode_e'(wr_data[MODE_HI:MODE_LO]);
                    rate_q <= wr_data[RATE_BIT];
                end
                RA_ENABLE: en_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           perr_q <= 1'b0;
        else if (step.bad) perr_q <= 1'b1;
        else if (clr_perr) perr_q <= 1'b0;
    end

    qpos_count #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en_q),
        .up       (step.up),
        .dn       (step.dn),
        .load     (load_cnt),
        .load_val (wr_data),
        .limit    (limit_q),
        .count    (pos_count)
    );

    always_comb begin
        rd_data = '0;
        unique case (addr)
            RA_COUNT:  rd_data = pos_count;
            RA_LIMIT:  rd_data = limit_q;
            RA_DECODE: rd_data[CTL_W-1:0] = pack_decode(mode_q, rate_q);
            RA_ENABLE: rd_data[1:0] = {perr_q, en_q};
            default:   rd_data = '0;
        endcase
    end

    assign phase_err = perr_q;

    p_perr_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (perr_q && !clr_perr) |=> perr_q);

    p_perr_set_r5: assert property (@(posedge clk) disable iff (rst)
        step.bad |=> perr_q);

    p_bad_no_step_r5: assert property (@(posedge clk) disable iff (rst)
        step.bad |-> !(step.up || step.dn));
endmodule

// File: tb/qpos_counter_tb.sv
module qpos_counter_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        enc_a, enc_b, wr_en;
    logic [1:0]  addr;
    logic [31:0] wr_data, rd_data, pos_count;
    logic        phase_err;

    int total = 0;
    int bad = 0;

    logic [31:0] m_cnt, m_max;
    logic [1:0]  m_mode;
    logic        m_rate, m_en, m_perr, m_a, m_b;

    qpos_counter u_dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .pos_count(pos_count), .phase_err(phase_err)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: m_cnt = d;
            2'd1: m_max = d;
            2'd2: begin m_mode = d[15:14]; m_rate = d[11]; end
            default: begin m_en = d[0]; if (d[1]) m_perr = 1'b0; end
        endcase
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(rd_data, exp, tag);
    endtask

    // Expected step for the model, from the requirements.
    task automatic model_move(input logic na, input logic nb);
        logic ea, eb, up, dn;
        ea = na != m_a; eb = nb != m_b; up = 0; dn = 0;
        case (m_mode)
            2'd0: if (ea && eb) m_perr = 1'b1;
                  else if (ea || eb) begin up = na ^ m_b; dn = ~(na ^ m_b); end
            2'd1: if (ea && na) begin up = nb; dn = ~nb; end
            2'd2: up = ea && (na || m_rate);
            default: dn = ea && (na || m_rate);
        endcase
        if (m_en && up) m_cnt = (m_cnt >= m_max) ? 32'd0 : m_cnt + 1;
        else if (m_en && dn) m_cnt = (m_cnt == 0) ? m_max : m_cnt - 1;
        m_a = na; m_b = nb;
    endtask

    task automatic move(input logic na, input logic nb, input string tag);
        @(negedge clk);
        enc_a = na; enc_b = nb;
        model_move(na, nb);
        repeat (3) @(negedge clk);
        check(pos_count, m_cnt, tag);
        check({31'd0, phase_err}, {31'd0, m_perr}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd4242));
        rst = 1'b1; enc_a = 0; enc_b = 0; wr_en = 0; addr = 0; wr_data = 0;
        m_cnt = 0; m_max = '1; m_mode = 0; m_rate = 0; m_en = 0; m_perr = 0; m_a = 0; m_b = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_check(2'd0, 32'd0, "R1 count");
        rd_check(2'd1, 32'hFFFF_FFFF, "R1 max");
        rd_check(2'd2, 32'd0, "R1 decode");
        rd_check(2'd3, 32'd0, "R1 enable/perr");

        // R2 register map
        wr(2'd2, 32'hFFFF_FFFF);
        rd_check(2'd2, 32'h0000_C800, "R2 decode fields");
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd9);
        rd_check(2'd1, 32'd9, "R2 max readback");

        // R3 disabled: edges ignored
        move(1, 0, "R3 disabled A");
        move(1, 1, "R3 disabled B");
        check(pos_count, 32'd0, "R3 count stays");
        move(0, 0, "R5 illegal while disabled");
        wr(2'd3, 32'd2);
        rd_check(2'd3, 32'd0, "R5 perr cleared");

        // R4 quadrature forward/back
        wr(2'd3, 32'd1);
        move(1, 0, "R4 up 1"); move(1, 1, "R4 up 2");
        move(0, 1, "R4 up 3"); move(0, 0, "R4 up 4");
        check(pos_count, 32'd4, "R4 four steps");
        move(0, 1, "R4 down 1"); move(1, 1, "R4 down 2");
        check(pos_count, 32'd2, "R4 reverse");

        // R5 illegal transition
        move(0, 0, "R5 both change");
        check({31'd0, phase_err}, 32'd1, "R5 flag set");
        move(1, 0, "R5 sticky");
        wr(2'd3, 32'd3);
        rd_check(2'd3, 32'd1, "R5 clear by write");

        // R8 wrap
        wr(2'd0, 32'd9);
        move(1, 1, "R8 wrap up to 0");
        check(pos_count, 32'd0, "R8 wrap up");
        move(1, 0, "R8 wrap down to max");
        check(pos_count, 32'd9, "R8 wrap down");

        // R6 direction mode
        wr(2'd2, 32'h0000_4000);
        wr(2'd0, 32'd5);
        move(0, 1, "R6 B edge no count");
        move(1, 1, "R6 rise B high up");
        move(0, 0, "R6 fall no count");
        move(1, 0, "R6 rise B low down");
        check(pos_count, 32'd5, "R6 net");

        // R7 up/down modes with rate bit
        wr(2'd2, 32'h0000_8000);
        move(1, 1, "R7 up B ignored");
        move(0, 1, "R7 up fall no count");
        move(0, 0, "R7 B ignored");
        wr(2'd2, 32'h0000_8800);
        move(1, 0, "R7 both edges rise");
        move(0, 0, "R7 both edges fall");
        wr(2'd2, 32'h0000_C800);
        move(1, 0, "R7 down rise");
        move(0, 0, "R7 down fall");
        check(pos_count, 32'd5, "R7 net");

        // R9 latency, mode 2 rising edges
        wr(2'd2, 32'h0000_8000);
        held = pos_count;
        @(negedge clk); enc_a = 1; model_move(1, 0);
        @(negedge clk); check(pos_count, held, "R9 after 1 edge");
        @(negedge clk); check(pos_count, held, "R9 after 2 edges");
        @(negedge clk); check(pos_count, m_cnt, "R9 after 3 edges");

        // R10 write coincides with event
        @(negedge clk); enc_a = 0;
        @(negedge clk); enc_a = 1;
        @(negedge clk);
        @(negedge clk); wr_en = 1; addr = 2'd0; wr_data = 32'd3;
        @(negedge clk); wr_en = 0; m_a = 1; m_cnt = 3;
        @(negedge clk); check(pos_count, 32'd3, "R10 write wins");

        // Random walk across modes
        wr(2'd1, 32'd12);
        wr(2'd0, 32'd6);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 16;
            if (op == 0) wr(2'd2, {16'd0, 2'($urandom), 2'd0, 1'($urandom), 11'd0});
            else if (op == 1) wr(2'd3, {30'd0, 1'($urandom), 1'($urandom % 4 == 0)});
            else if (m_mode == 2'd0 && op != 2) begin
                if ($urandom % 2) move(m_b ? ~m_a : m_a, m_b ? m_b : ~m_b, "R4 random");
                else move(~m_b ^ m_a ? m_a : m_a, m_b, "R4 random hold");
                if ($urandom % 2) move(~m_a, m_b, "R4 random A");
                else move(m_a, ~m_b, "R4 random B");
            end else if (op == 2) move(~m_a, ~m_b, "R5 random both");
            else move(1'($urandom), 1'($urandom), "R6/R7 random");
        end
        rd_check(2'd0, m_cnt, "R8 final count");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule